// File: doc/BRIEF.md
# Rotating Register File Renamer

This block is a register file for a statically scheduled core in which the upper part of the register space renames itself once per loop iteration. A register base value is combined, modulo the size of the rotating region, with every logical index that falls inside that region. Indices below the region address storage directly. Because the base shifts by one on every loop-closing branch, a value written under logical name n in one iteration is found under name n+1 in the next. A compiler can therefore express the distance between a producer and a consumer as a register-number offset, and a single loop body covers the prologue, kernel and epilogue of a software-pipelined loop.

The file has two read ports and one write port, all addressed by logical index. A one-cycle branch pulse steps the base, and a clear input returns it to zero. Read data is combinational and includes a bypass from the write port in the same cycle. Register 0 is a hard zero.

Top module: `rrf_renamer`

## Requirements
- R1: A logical index below NUM_STATIC (default 32) addresses its own physical entry, whatever the base value.
- R2: Logical index 0 always reads as zero, and writes to index 0 change no register.
- R3: A logical index n at or above NUM_STATIC maps to physical entry NUM_STATIC + ((n - NUM_STATIC + base) mod (NUM_REGS - NUM_STATIC)).
- R4: A branch pulse lowers the base by one, wrapping from 0 to NUM_REGS-NUM_STATIC-1. The new base applies from the cycle after the pulse, and reads and writes in the pulse cycle use the old base. A value written as rotating index n is therefore read as n+1 after one branch, and the highest index wraps to NUM_STATIC.
- R5: A clear pulse sets the base to 0 from the next cycle, and it wins over a branch pulse in the same cycle.
- R6: When the write port and a read port select the same physical entry in the same cycle, the read returns the data being written.
- R7: After reset the base is 0 and every register reads zero.
- R8: The two read ports operate independently and may address any two indices in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Return the rotation base to zero |
| loop_br_i | input | 1 | Loop-closing branch pulse, steps the base |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | $clog2(NUM_REGS) | Logical index written |
| wr_data_i | input | DATA_W | Write data |
| rd0_idx_i | input | $clog2(NUM_REGS) | Logical index for read port 0 |
| rd0_data_o | output | DATA_W | Read port 0 data |
| rd1_idx_i | input | $clog2(NUM_REGS) | Logical index for read port 1 |
| rd1_data_o | output | DATA_W | Read port 1 data |

## Verification
The bench builds the block with NUM_REGS=16, NUM_STATIC=4 and DATA_W=16, which leaves a rotating region of 12 entries. At that size the bench can write and read back every logical index at every base value, and it can step the base through more than a full turn, so the wrap from 0 to 11 and the wrap of the top index onto the first rotating one both occur. Branch, clear and bypass cycles are placed at several base values so that the pulse-cycle behaviour and the priority of clear over branch are each seen at more than one point of the rotation.

// File: rtl/rrf_pkg.sv
package rrf_pkg;

    typedef enum logic [1:0] {
        BASE_HOLD = 2'd0,
        BASE_STEP = 2'd1,
        BASE_ZERO = 2'd2
    } base_op_e;

endpackage

// File: rtl/rrf_base_ctrl.sv
module rrf_base_ctrl #(
    parameter int unsigned ROT_SIZE = 96,
    localparam int unsigned RRB_W   = $clog2(ROT_SIZE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             loop_br_i,
    output logic [RRB_W-1:0] rrb_o
);
    import rrf_pkg::*;

    localparam logic [RRB_W-1:0] RRB_TOP = RRB_W'(ROT_SIZE - 1);

    typedef struct packed {
        logic [RRB_W-1:0] rrb;
    } base_st_t;

    base_st_t st_d, st_q;
    base_op_e op;

    always_comb begin
        if (clear_i)        op = BASE_ZERO;
        else if (loop_br_i) op = BASE_STEP;
        else                op = BASE_HOLD;
    end

    always_comb begin
        st_d = st_q;
        unique case (op)
            BASE_ZERO: st_d.rrb = '0;
            BASE_STEP: st_d.rrb = (st_q.rrb == '0) ? RRB_TOP : st_q.rrb - 1'b1;
            default:   st_d.rrb = st_q.rrb;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rrb_o = st_q.rrb;

    // R4
    rrb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(loop_br_i) && !$past(clear_i) && $past(rrb_o) != '0)
            |-> (rrb_o + 1'b1 == $past(rrb_o)));

    // R4
    rrb_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(loop_br_i) && !$past(clear_i) && $past(rrb_o) == '0)
            |-> (rrb_o == RRB_TOP));

    // R5
    rrb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (rrb_o == '0));

    // R4
    rrb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !loop_br_i) |=> $stable(rrb_o));

    // R3
    rrb_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rrb_o <= RRB_TOP);

endmodule

// File: rtl/rrf_map.sv
module rrf_map #(
    parameter int unsigned NUM_REGS   = 128,
    parameter int unsigned NUM_STATIC = 32,
    localparam int unsigned IDX_W     = $clog2(NUM_REGS),
    localparam int unsigned ROT_SIZE  = NUM_REGS - NUM_STATIC,
    localparam int unsigned RRB_W     = $clog2(ROT_SIZE)
) (
    input  logic [IDX_W-1:0] log_idx_i,
    input  logic [RRB_W-1:0] rrb_i,
    output logic [IDX_W-1:0] phys_idx_o
);
    localparam int unsigned SW = IDX_W + 1;
    localparam logic [SW-1:0] ST_E  = SW'(NUM_STATIC);
    localparam logic [SW-1:0] ROT_E = SW'(ROT_SIZE);

    logic          in_rot;
    logic [SW-1:0] off;
    logic [SW-1:0] sum;
    logic [SW-1:0] wrapped;
    logic [SW-1:0] full;

    always_comb begin
        in_rot  = ({1'b0, log_idx_i} >= ST_E);
        off     = {1'b0, log_idx_i} - ST_E;
        sum     = off + SW'(rrb_i);
        wrapped = (sum >= ROT_E) ? sum - ROT_E : sum;
        full    = wrapped + ST_E;
        phys_idx_o = in_rot ? full[IDX_W-1:0] : log_idx_i;
    end

    // R3
    always_comb begin
        if (in_rot) begin
            map_range_chk: assert (phys_idx_o >= IDX_W'(NUM_STATIC));
        end
    end

endmodule

// File: rtl/rrf_storage.sv
module rrf_storage #(
    parameter int unsigned NUM_REGS = 128,
    parameter int unsigned DATA_W   = 64,
    parameter int unsigned NUM_RD   = 2,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en_i,
    input  logic [IDX_W-1:0]               wr_phys_i,
    input  logic [DATA_W-1:0]              wr_data_i,
    input  logic [NUM_RD-1:0][IDX_W-1:0]   rd_phys_i,
    output logic [NUM_RD-1:0][DATA_W-1:0]  rd_data_o
);
    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] mem;
    } store_st_t;

    store_st_t st_d, st_q;
    logic      wr_live;

    assign wr_live = wr_en_i && (wr_phys_i != '0);

    always_comb begin
        st_d = st_q;
        if (wr_live) st_d.mem[wr_phys_i] = wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < int'(NUM_RD); g++) begin : g_rd
        always_comb begin
            if (rd_phys_i[g] == '0)
                rd_data_o[g] = '0;
            else if (wr_live && wr_phys_i == rd_phys_i[g])
                rd_data_o[g] = wr_data_i;
            else
                rd_data_o[g] = st_q.mem[rd_phys_i[g]];
        end
    end

    // R2
    zero_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mem[0] == '0);

    // R6
    write_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_live |=> (st_q.mem[$past(wr_phys_i)] == $past(wr_data_i)));

    // R2
    zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_phys_i == '0) |=> (st_q.mem == $past(st_q.mem)));

endmodule

// File: rtl/rrf_renamer.sv
module rrf_renamer #(
    parameter int unsigned NUM_REGS   = 128,
    parameter int unsigned NUM_STATIC = 32,
    parameter int unsigned DATA_W     = 64,
    localparam int unsigned IDX_W     = $clog2(NUM_REGS),
    localparam int unsigned ROT_SIZE  = NUM_REGS - NUM_STATIC,
    localparam int unsigned RRB_W     = $clog2(ROT_SIZE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              loop_br_i,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [IDX_W-1:0]  rd0_idx_i,
    output logic [DATA_W-1:0] rd0_data_o,
    input  logic [IDX_W-1:0]  rd1_idx_i,
    output logic [DATA_W-1:0] rd1_data_o
);
    localparam int unsigned NUM_RD  = 2;
    localparam int unsigned NUM_MAP = NUM_RD + 1;

    logic [RRB_W-1:0]                 rrb;
    logic [NUM_MAP-1:0][IDX_W-1:0]    log_idx;
    logic [NUM_MAP-1:0][IDX_W-1:0]    phys_idx;
    logic [NUM_RD-1:0][IDX_W-1:0]     rd_phys;
    logic [NUM_RD-1:0][DATA_W-1:0]    rd_data;

    rrf_base_ctrl #(.ROT_SIZE(ROT_SIZE)) i_base (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear_i),
        .loop_br_i (loop_br_i),
        .rrb_o     (rrb)
    );

    assign log_idx[0] = rd0_idx_i;
    assign log_idx[1] = rd1_idx_i;
    assign log_idx[2] = wr_idx_i;

    for (genvar m = 0; m < int'(NUM_MAP); m++) begin : g_map
        rrf_map #(
            .NUM_REGS   (NUM_REGS),
            .NUM_STATIC (NUM_STATIC)
        ) i_map (
            .log_idx_i  (log_idx[m]),
            .rrb_i      (rrb),
            .phys_idx_o (phys_idx[m])
        );
    end

    assign rd_phys[0] = phys_idx[0];
    assign rd_phys[1] = phys_idx[1];

    rrf_storage #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .NUM_RD   (NUM_RD)
    ) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_phys_i (phys_idx[2]),
        .wr_data_i (wr_data_i),
        .rd_phys_i (rd_phys),
        .rd_data_o (rd_data)
    );

    assign rd0_data_o = rd_data[0];
    assign rd1_data_o = rd_data[1];

    // R2
    zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_idx_i == '0) |-> (rd0_data_o == '0));

    // R1
    static_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_idx_i < IDX_W'(NUM_STATIC)) |-> (phys_idx[2] == wr_idx_i));

endmodule

// File: tb/test_rrf_renamer.sv
module test_rrf_renamer;
    localparam int NR   = 16;
    localparam int NS   = 4;
    localparam int DW   = 16;
    localparam int ROT  = NR - NS;
    localparam int IW   = $clog2(NR);
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear_i = 1'b0, loop_br_i = 1'b0, wr_en_i = 1'b0;
    logic [IW-1:0] wr_idx_i = '0, rd0_idx_i = '0, rd1_idx_i = '0;
    logic [DW-1:0] wr_data_i = '0;
    logic [DW-1:0] rd0_data_o, rd1_data_o;

    int n_tests = 0;
    int n_fail  = 0;
    int m_rrb   = 0;
    logic [DW-1:0] m_mem [NR];

    always #(CLK_PERIOD/2) clk = ~clk;

    rrf_renamer #(.NUM_REGS(NR), .NUM_STATIC(NS), .DATA_W(DW)) i_rrf_renamer (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .loop_br_i(loop_br_i),
        .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
        .rd0_idx_i(rd0_idx_i), .rd0_data_o(rd0_data_o),
        .rd1_idx_i(rd1_idx_i), .rd1_data_o(rd1_data_o)
    );

    function automatic int phys(input int n);
        if (n < NS) return n;
        return NS + ((n - NS + m_rrb) % ROT);
    endfunction

    function automatic logic [DW-1:0] expect_rd(input int r, input logic we,
                                                input int w, input logic [DW-1:0] wd);
        if (r == 0) return '0;
        if (we && w != 0 && phys(w) == phys(r)) return wd;
        return m_mem[phys(r)];
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h (rrb model %0d)", tag, got, exp, m_rrb);
        end
    endtask

    // One cycle: drive at falling edge, check reads, then let the edge commit.
    task automatic cyc(input string tag, input logic br, input logic clr,
                       input logic we, input int w, input logic [DW-1:0] wd,
                       input int r0, input int r1, input logic chk);
        @(negedge clk);
        loop_br_i = br; clear_i = clr; wr_en_i = we;
        wr_idx_i = IW'(w); wr_data_i = wd;
        rd0_idx_i = IW'(r0); rd1_idx_i = IW'(r1);
        #1;
        if (chk) begin
            check(tag, rd0_data_o, expect_rd(r0, we, w, wd));
            check(tag, rd1_data_o, expect_rd(r1, we, w, wd));
        end
        @(posedge clk);
        if (we && w != 0) m_mem[phys(w)] = wd;
        if (clr)     m_rrb = 0;
        else if (br) m_rrb = (m_rrb == 0) ? ROT - 1 : m_rrb - 1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NR; i++) m_mem[i] = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R7: reset contents all zero on both ports
        for (int n = 0; n < NR; n++) cyc("R7 reset", 0, 0, 0, 0, 0, n, NR - 1 - n, 1);

        // R2: write to index 0 ignored, reads zero
        cyc("R2 zero write", 0, 0, 1, 0, 16'hFFFF, 0, 0, 1);
        cyc("R2 zero read", 0, 0, 0, 0, 0, 0, 0, 1);

        // R1 R3 R8 R4: full sweep of indices at each base, more than one full turn
        for (int k = 0; k < ROT + 2; k++) begin
            for (int n = 1; n < NR; n++)
                cyc("R3 fill", 0, 0, 1, n, DW'((k << 8) | n), 0, 0, 0);
            for (int n = 0; n < NR; n++)
                cyc("R1 R3 R8 sweep", 0, 0, 0, 0, 0, n, (n * 7) % NR, 1);
            // R4: pulse-cycle write and read use old base
            cyc("R4 pulse cycle", 1, 0, 1, NS + (k % ROT), DW'(16'hA000 | k),
                NS + (k % ROT), NR - 1, 1);
        end

        // R4: explicit n -> n+1 after one branch, top index wraps to first rotating
        cyc("R4 setup", 0, 0, 1, NR - 1, 16'hBEEF, 0, 0, 0);
        cyc("R4 setup", 0, 0, 1, NS + 2, 16'h1234, 0, 0, 0);
        cyc("R4 branch", 1, 0, 0, 0, 0, 0, 0, 0);
        cyc("R4 wrap", 0, 0, 0, 0, 0, NS, NS + 3, 0);
        check("R4 top wraps to first rotating", rd0_data_o, 16'hBEEF);
        check("R4 n read as n+1", rd1_data_o, 16'h1234);

        // R6: bypass on both ports, static and rotating
        cyc("R6 bypass rot", 0, 0, 1, NS + 5, 16'h5A5A, NS + 5, NS + 5, 1);
        check("R6 bypass port0", rd0_data_o, 16'h5A5A);
        cyc("R6 bypass static", 0, 0, 1, 2, 16'h0C0C, 2, 3, 1);
        check("R6 bypass static port0", rd0_data_o, 16'h0C0C);

        // R5: clear wins over branch; base back to zero
        cyc("R5 branch", 1, 0, 0, 0, 0, 0, 0, 0);
        cyc("R5 branch", 1, 0, 0, 0, 0, 0, 0, 0);
        cyc("R5 clear+branch", 1, 1, 0, 0, 0, NS, NS + 1, 1);
        for (int n = NS; n < NR; n++)
            cyc("R5 after clear", 0, 0, 0, 0, 0, n, NR - 1, 1);
        cyc("R5 clear alone", 0, 1, 0, 0, 0, 0, 0, 0);
        for (int n = NS; n < NR; n++)
            cyc("R5 clear at zero", 0, 0, 0, 0, 0, n, NS, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule